// File: doc/BRIEF.md
# DMA Beat and Transfer Count Sequencer

This block sequences one DMA channel. When a start pulse arrives, it takes in three settings: a 4-bit beat type, a 4-bit inner count and a 16-bit outer count. It then drives a simplified bus-master command interface and moves data in alternating phases. A read phase fetches a burst from the source, and a write phase pushes the same burst to the destination. Read data waits in a 64-byte staging FIFO, so one 16-beat burst of 32-bit words fits between the two phases.

The beat type selects the burst shape, which is either single beats, incrementing bursts or wrapping bursts. The inner count has two uses. In single-beat mode it is the number of read/write pairs per block. In undefined-length incrementing mode it gives the burst length. Fixed-length bursts ignore it. Software sees the live inner and outer counts while the transfer runs. A one-cycle done pulse marks normal completion, and both counts read zero at that point. An illegal setting raises an error flag and no transfer starts.

Top module: `dma_beat_seq`

## Requirements
- R1: Beat type sets the burst shape. Codes 0h and 8h give 1 beat. Code 9h gives an incrementing burst of (inner count + 1) beats. Codes Bh, Dh and Fh give incrementing bursts of 4, 8 and 16 beats. Codes Ah, Ch and Eh give wrapping bursts of 4, 8 and 16 beats. `cmd_wrap_o` is 1 only for the wrapping codes. `cmd_beats_o` carries the beat count.
- R2: A start with beat type 1h to 7h sets `err_o` in the cycle after the start, keeps `busy_o` low and issues no command.
- R3: When `demand_i` is high at start, only beat type 0h or 8h with inner count 0 is accepted. Any other setting behaves as in R2.
- R4: Every burst begins with a read command (`cmd_write_o`=0) followed by exactly N read beats. A write command (`cmd_write_o`=1) then follows with exactly N write beats. This pattern repeats. In single-beat mode N is 1, so reads and writes strictly alternate. No command or write beat appears while idle.
- R5: In single-beat mode the transfer performs (inner+1)×(outer+1) pairs. `bc_o` falls by one after each pair. When a pair completes with `bc_o` at 0, `tc_o` falls by one and `bc_o` reloads its programmed value.
- R6: In burst modes the transfer performs outer+1 read/write burst pairs. `tc_o` falls by one after each completed pair and never rises during a transfer.
- R7: In undefined-length incrementing mode, `bc_o` reads 0 for the whole transfer.
- R8: Fixed-length burst modes ignore the inner count. The burst length is unaffected by it and `bc_o` reads 0.
- R9: Beat addresses appear on `beat_addr_o`. Incrementing beat k is at base+4k. Wrapping beats stay inside the aligned window of N×4 bytes that contains the base, and wrap modulo that window. Each burst's base (`cmd_addr_o`) is the previous base plus 4N, separately for source and destination.
- R10: Write beats carry the read data in the order it was read.
- R11: On normal completion `done_o` pulses for one cycle. In that cycle `busy_o` is low and `bc_o` and `tc_o` are zero.
- R12: A pending command keeps `cmd_valid_o`, `cmd_addr_o`, `cmd_write_o` and `cmd_beats_o` stable until `cmd_ready_i` is seen.
- R13: A start pulse while busy is ignored. It raises no error and does not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| demand_i | input | 1 | Demand-mode flag, checked at start |
| bt_i | input | 4 | Beat type code |
| bc_i | input | 4 | Inner count (blocks minus one, or burst length minus one) |
| tc_i | input | 16 | Outer count minus one |
| src_addr_i | input | 32 | Source start address |
| dst_addr_i | input | 32 | Destination start address |
| cmd_valid_o | output | 1 | Command request |
| cmd_ready_i | input | 1 | Command accept |
| cmd_write_o | output | 1 | 0 for read phase, 1 for write phase |
| cmd_addr_o | output | 32 | Burst base address |
| cmd_wrap_o | output | 1 | Wrapping burst |
| cmd_beats_o | output | 5 | Beats in burst |
| beat_addr_o | output | 32 | Address of current beat |
| rd_valid_i | input | 1 | Read beat valid |
| rd_data_i | input | 32 | Read beat data |
| wr_valid_o | output | 1 | Write beat valid |
| wr_data_o | output | 32 | Write beat data |
| wr_ready_i | input | 1 | Write beat accept |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected start, held until next accepted start |
| bc_o | output | 4 | Live inner count |
| tc_o | output | 16 | Live outer count |

## Verification
The assertions check several properties on every cycle. Commands must hold steady until accepted, and nothing is issued while idle. The outer count never rises within a transfer. The done pulse lasts one cycle and comes with zeroed counts. A rejected start leaves the block idle. Wrapping beats stay inside their window. Other properties depend on the whole course of a transfer, so only the bench scenarios can show them:
- the exact number of pairs per mode;
- the reload of the inner count between blocks;
- the data order through the FIFO;
- the burst base progression;
- the decode of every beat type.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  parameter int unsigned MAX_BEATS = 16;
  localparam int unsigned BEAT_W = $clog2(MAX_BEATS) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CMD, ST_RD_DAT, ST_WR_CMD, ST_WR_DAT
  } seq_state_e;

  typedef struct packed {
    logic              single;
    logic              wrap;
    logic [BEAT_W-1:0] beats;
  } burst_cfg_t;
endpackage

// File: rtl/dma_beat_decode.sv
module dma_beat_decode
  import dma_seq_pkg::*;
#(
  parameter int unsigned BTW = 4,
  parameter int unsigned BCW = 4
) (
  input  logic [BTW-1:0] bt_i,
  input  logic [BCW-1:0] bc_i,
  input  logic           demand_i,
  output burst_cfg_t     cfg_o,
  output logic           illegal_o
);
  logic legal_code;

  always_comb begin
    cfg_o      = '0;
    legal_code = 1'b1;
    if (bt_i == '0 || bt_i == BTW'(8)) begin
      cfg_o.single = 1'b1;
      cfg_o.beats  = BEAT_W'(1);
    end else if (bt_i == BTW'(9)) begin
      cfg_o.beats  = BEAT_W'(bc_i) + BEAT_W'(1);
    end else if (bt_i[3]) begin
      // A..F: even codes wrap, bt[2:1] selects 4/8/16
      cfg_o.wrap   = ~bt_i[0];
      cfg_o.beats  = BEAT_W'(2) << bt_i[2:1];
    end else begin
      legal_code   = 1'b0;
    end
  end

  assign illegal_o = !legal_code || (demand_i && (!cfg_o.single || bc_i != '0));
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]     base_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              wrap_i,
  input  logic [BEAT_W-1:0] idx_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     next_base_o
);
  logic [AW-1:0] span, mask, lin;

  assign span        = AW'({beats_i, 2'b00});
  assign mask        = span - AW'(1);
  assign lin         = base_i + AW'({idx_i, 2'b00});
  assign addr_o      = wrap_i ? ((base_i & ~mask) | (lin & mask)) : lin;
  assign next_base_o = base_i + span;
endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + PW'(1);
      if (pop_i)  rd_ptr <= rd_ptr + PW'(1);
      cnt <= cnt + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  assign dout_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned BTW        = 4,
  parameter int unsigned BCW        = 4,
  parameter int unsigned TCW        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              demand_i,
  input  logic [BTW-1:0]    bt_i,
  input  logic [BCW-1:0]    bc_i,
  input  logic [TCW-1:0]    tc_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_write_o,
  output logic [AW-1:0]     cmd_addr_o,
  output logic              cmd_wrap_o,
  output logic [BEAT_W-1:0] cmd_beats_o,
  output logic [AW-1:0]     beat_addr_o,
  input  logic              rd_valid_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              wr_valid_o,
  output logic [DW-1:0]     wr_data_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [BCW-1:0]    bc_o,
  output logic [TCW-1:0]    tc_o
);
  localparam int unsigned DEPTH = FIFO_BYTES / (DW / 8);

  seq_state_e    state_q;
  burst_cfg_t    cfg_q, dec_cfg;
  logic          dec_illegal;
  logic [BCW-1:0]    bc_q, bc_rld_q;
  logic [TCW-1:0]    tc_q;
  logic [AW-1:0]     src_q, dst_q, base_sel, next_base;
  logic [BEAT_W-1:0] beat_q, last_beat;
  logic          done_q, err_q, fifo_empty, wr_phase, push, pop, last_pair;

  dma_beat_decode #(.BTW(BTW), .BCW(BCW)) u_dec (
    .bt_i(bt_i), .bc_i(bc_i), .demand_i(demand_i),
    .cfg_o(dec_cfg), .illegal_o(dec_illegal)
  );

  assign wr_phase = (state_q == ST_WR_CMD) || (state_q == ST_WR_DAT);
  assign base_sel = wr_phase ? dst_q : src_q;

  dma_addr_step #(.AW(AW)) u_addr (
    .base_i(base_sel), .beats_i(cfg_q.beats), .wrap_i(cfg_q.wrap), .idx_i(beat_q),
    .addr_o(beat_addr_o), .next_base_o(next_base)
  );

  assign push = (state_q == ST_RD_DAT) && rd_valid_i;
  assign pop  = wr_valid_o && wr_ready_i;

  dma_stage_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .din_i(rd_data_i),
    .pop_i(pop), .dout_o(wr_data_o), .empty_o(fifo_empty)
  );

  assign last_beat = cfg_q.beats - BEAT_W'(1);
  assign last_pair = (tc_q == '0) && (!cfg_q.single || bc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cfg_q    <= '0;
      bc_q     <= '0;
      bc_rld_q <= '0;
      tc_q     <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      beat_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (dec_illegal) begin
            err_q <= 1'b1;
          end else begin
            err_q    <= 1'b0;
            cfg_q    <= dec_cfg;
            bc_q     <= dec_cfg.single ? bc_i : '0;
            bc_rld_q <= bc_i;
            tc_q     <= tc_i;
            src_q    <= src_addr_i;
            dst_q    <= dst_addr_i;
            beat_q   <= '0;
            state_q  <= ST_RD_CMD;
          end
        end
        ST_RD_CMD: if (cmd_ready_i) state_q <= ST_RD_DAT;
        ST_RD_DAT: if (rd_valid_i) begin
          if (beat_q == last_beat) begin
            beat_q  <= '0;
            src_q   <= next_base;
            state_q <= ST_WR_CMD;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        ST_WR_CMD: if (cmd_ready_i) state_q <= ST_WR_DAT;
        ST_WR_DAT: if (pop) begin
          if (beat_q == last_beat) begin
            beat_q <= '0;
            dst_q  <= next_base;
            if (last_pair) begin
              bc_q    <= '0;
              tc_q    <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              // single mode: inner count first, outer count on block boundary
              if (cfg_q.single && bc_q != '0) begin
                bc_q <= bc_q - BCW'(1);
              end else begin
                tc_q <= tc_q - TCW'(1);
                bc_q <= cfg_q.single ? bc_rld_q : '0;
              end
              state_q <= ST_RD_CMD;
            end
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == ST_RD_CMD) || (state_q == ST_WR_CMD);
  assign cmd_write_o = (state_q == ST_WR_CMD);
  assign cmd_addr_o  = base_sel;
  assign cmd_wrap_o  = cfg_q.wrap;
  assign cmd_beats_o = cfg_q.beats;
  assign wr_valid_o  = (state_q == ST_WR_DAT) && !fifo_empty;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign bc_o        = bc_q;
  assign tc_o        = tc_q;
endmodule

// File: rtl/dma_beat_seq_chk.sv
module dma_beat_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned BCW = 4,
  parameter int unsigned TCW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic              cmd_write_o,
  input logic [AW-1:0]     cmd_addr_o,
  input logic              cmd_wrap_o,
  input logic [BEAT_W-1:0] cmd_beats_o,
  input logic [AW-1:0]     beat_addr_o,
  input logic              wr_valid_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [BCW-1:0]    bc_o,
  input logic [TCW-1:0]    tc_o
);
  logic [AW-1:0] win_mask;
  assign win_mask = AW'({cmd_beats_o, 2'b00}) - AW'(1);

  assert_cmd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o)
      && $stable(cmd_write_o) && $stable(cmd_beats_o));

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o && !wr_valid_o);

  assert_err_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  assert_done_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && bc_o == '0 && tc_o == '0);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_tc_no_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> tc_o <= $past(tc_o));

  assert_beats_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_beats_o != '0 && cmd_beats_o <= BEAT_W'(MAX_BEATS));

  assert_wrap_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_wrap_o |-> ((beat_addr_o ^ cmd_addr_o) & ~win_mask) == '0);
endmodule

bind dma_beat_seq dma_beat_seq_chk #(.AW(AW), .BCW(BCW), .TCW(TCW)) u_chk (.*);

// File: tb/dma_beat_seq_bench.sv
`timescale 1ns/1ps
module dma_beat_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start, demand, cmd_ready, rd_valid, wr_ready;
  logic [3:0] bt, bc;
  logic [15:0] tc;
  logic [31:0] src, dst, rd_data;
  logic cmd_valid, cmd_write, cmd_wrap, wr_valid, busy, done, err;
  logic [31:0] cmd_addr, beat_addr, wr_data;
  logic [4:0] cmd_beats;
  logic [3:0] bc_q_o;
  logic [15:0] tc_q_o;

  int checks = 0, fails = 0, seen = 0;
  typedef struct { logic [31:0] addr; logic [31:0] data; } wr_item_t;
  wr_item_t exp_q[$];

  always #4 clk = ~clk;

  dma_beat_seq u_dma_beat_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .demand_i(demand),
    .bt_i(bt), .bc_i(bc), .tc_i(tc), .src_addr_i(src), .dst_addr_i(dst),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_write_o(cmd_write),
    .cmd_addr_o(cmd_addr), .cmd_wrap_o(cmd_wrap), .cmd_beats_o(cmd_beats),
    .beat_addr_o(beat_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
    .busy_o(busy), .done_o(done), .err_o(err), .bc_o(bc_q_o), .tc_o(tc_q_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int n, input bit wrap, input int k);
    logic [31:0] win, lo;
    if (!wrap) return base + 32'(4 * k);
    win = 32'(4 * n);
    lo  = base - (base % win);
    return lo + ((base - lo + 32'(4 * k)) % win);
  endfunction

  // monitor: pop expected write beats as they are accepted
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 extra write beat", 32'(seen), 32'(0));
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        chk(wr_data == it.data, "R10 write data", wr_data, it.data);
        chk(beat_addr == it.addr, "R9 write beat address", beat_addr, it.addr);
      end
      seen++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_cmd(input bit wr, input logic [31:0] base, input int n, input bit wrap, input string req);
    int t = 0;
    @(negedge clk); #1;
    while (!cmd_valid && t < 60) begin
      @(negedge clk); #1;
      t++;
    end
    chk(cmd_valid, {req, " R4 command issued"}, 32'(cmd_valid), 32'(1));
    chk(cmd_write == wr, {req, " R4 phase order"}, 32'(cmd_write), 32'(wr));
    chk(cmd_addr == base, {req, " R9 burst base"}, cmd_addr, base);
    chk(cmd_beats == 5'(n), {req, " R1 beat count"}, 32'(cmd_beats), 32'(n));
    chk(cmd_wrap == wrap, {req, " R1 wrap kind"}, 32'(cmd_wrap), 32'(wrap));
  endtask

  task automatic handshake(input bit stall);
    step();
    if (stall) step();
    cmd_ready = 1'b1;
    step();
    cmd_ready = 1'b0;
  endtask

  task automatic drive_start(input logic [3:0] b, input logic [3:0] c, input logic [15:0] t, input bit dm,
                             input logic [31:0] s, input logic [31:0] d);
    step();
    bt = b; bc = c; tc = t; demand = dm; src = s; dst = d; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic xfer(input logic [3:0] b, input logic [3:0] c, input logic [15:0] t, input bit dm,
                      input logic [31:0] s, input logic [31:0] d, input bit poke, input string req);
    int n, pairs, cyc;
    bit wrap, single;
    single = (b == 4'h0 || b == 4'h8);
    wrap = 1'b0;
    case (b)
      4'h0, 4'h8: n = 1;
      4'h9: n = int'(c) + 1;
      4'hA: begin n = 4;  wrap = 1'b1; end
      4'hB: n = 4;
      4'hC: begin n = 8;  wrap = 1'b1; end
      4'hD: n = 8;
      4'hE: begin n = 16; wrap = 1'b1; end
      default: n = 16;
    endcase
    pairs = single ? (int'(c) + 1) * (int'(t) + 1) : int'(t) + 1;
    drive_start(b, c, t, dm, s, d);
    cyc = 0;
    for (int p = 0; p < pairs; p++) begin
      logic [31:0] sb, db;
      logic [3:0] exp_bc;
      logic [15:0] exp_tc;
      sb = s + 32'(4 * n * p);
      db = d + 32'(4 * n * p);
      wait_cmd(1'b0, sb, n, wrap, req);
      if (single) begin
        exp_bc = c - 4'(p % (int'(c) + 1));
        exp_tc = t - 16'(p / (int'(c) + 1));
        chk(bc_q_o == exp_bc, {req, " R5 live inner count"}, 32'(bc_q_o), 32'(exp_bc));
        chk(tc_q_o == exp_tc, {req, " R5 live outer count"}, 32'(tc_q_o), 32'(exp_tc));
      end else begin
        exp_tc = t - 16'(p);
        chk(tc_q_o == exp_tc, {req, " R6 live outer count"}, 32'(tc_q_o), 32'(exp_tc));
        chk(bc_q_o == 4'h0, {req, " R7 R8 inner count reads zero"}, 32'(bc_q_o), 32'(0));
      end
      handshake(p % 2 == 1);
      if (poke && p == 0) begin
        bt = 4'h3; bc = 4'h7; tc = 16'h0009; start = 1'b1;
        step();
        start = 1'b0;
      end
      for (int k = 0; k < n; k++) begin
        logic [31:0] ra, wa;
        wr_item_t it;
        ra = exp_addr(sb, n, wrap, k);
        wa = exp_addr(db, n, wrap, k);
        it.addr = wa;
        it.data = ra ^ 32'hC3C3_0000;
        exp_q.push_back(it);
        rd_valid = 1'b1;
        rd_data = it.data;
        @(negedge clk); #1;
        chk(beat_addr == ra, {req, " R9 read beat address"}, beat_addr, ra);
        step();
        if (k % 3 == 1) begin
          rd_valid = 1'b0;
          step();
        end
      end
      rd_valid = 1'b0;
      wait_cmd(1'b1, db, n, wrap, req);
      handshake(p % 2 == 0);
      begin
        int target = seen + n;
        while (seen < target) begin
          step();
          wr_ready = (cyc % 3 != 2);
          cyc++;
          @(negedge clk); #1;
        end
      end
      step();
      wr_ready = 1'b0;
    end
    @(negedge clk); #1;
    chk(done, {req, " R11 done pulse"}, 32'(done), 32'(1));
    chk(!busy, {req, " R11 idle at done"}, 32'(busy), 32'(0));
    chk(bc_q_o == 4'h0 && tc_q_o == 16'h0, {req, " R11 counts cleared"}, {bc_q_o, tc_q_o}, 32'(0));
    chk(exp_q.size() == 0, {req, " R4 all write beats seen"}, 32'(exp_q.size()), 32'(0));
    if (poke) chk(!err, {req, " R13 start while busy ignored"}, 32'(err), 32'(0));
    step();
    chk(!done, {req, " R11 done is one cycle"}, 32'(done), 32'(0));
  endtask

  task automatic reject(input logic [3:0] b, input logic [3:0] c, input bit dm, input string req);
    drive_start(b, c, 16'h0003, dm, 32'h4000, 32'h5000);
    @(negedge clk); #1;
    chk(err, {req, " error flag"}, 32'(err), 32'(1));
    chk(!busy && !cmd_valid, {req, " transfer not started"}, {busy, cmd_valid}, 32'(0));
    repeat (3) begin
      step();
      chk(!cmd_valid, {req, " no command"}, 32'(cmd_valid), 32'(0));
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    start = 0; demand = 0; cmd_ready = 0; rd_valid = 0; wr_ready = 0;
    bt = 0; bc = 0; tc = 0; src = 0; dst = 0; rd_data = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !cmd_valid && !wr_valid && !done && !err, "R4 R11 reset state",
        {busy, cmd_valid, wr_valid, done, err}, 32'(0));
    chk(bc_q_o == 0 && tc_q_o == 0, "R5 reset counts", {bc_q_o, tc_q_o}, 32'(0));

    xfer(4'h0, 4'h2, 16'h0001, 1'b0, 32'h0000_1000, 32'h0000_2000, 1'b0, "R5 single 0h");
    xfer(4'h8, 4'h0, 16'h0002, 1'b0, 32'h0000_1100, 32'h0000_2100, 1'b0, "R5 single 8h");
    xfer(4'hB, 4'h5, 16'h0001, 1'b0, 32'h0000_1200, 32'h0000_2200, 1'b0, "R8 INCR4");
    xfer(4'hA, 4'h3, 16'h0001, 1'b0, 32'h0000_1008, 32'h0000_3004, 1'b0, "R9 WRAP4");
    xfer(4'hC, 4'h0, 16'h0000, 1'b0, 32'h0000_100C, 32'h0000_3018, 1'b0, "R9 WRAP8");
    xfer(4'h9, 4'h2, 16'h0001, 1'b0, 32'h0000_1300, 32'h0000_2300, 1'b0, "R7 INCR undefined");
    xfer(4'hF, 4'h1, 16'h0000, 1'b0, 32'h0000_1400, 32'h0000_2400, 1'b0, "R1 INCR16");
    xfer(4'hE, 4'h0, 16'h0000, 1'b0, 32'h0000_1034, 32'h0000_3078, 1'b0, "R9 WRAP16");
    xfer(4'hD, 4'h9, 16'h0001, 1'b0, 32'h0000_1500, 32'h0000_2500, 1'b1, "R13 INCR8");

    reject(4'h3, 4'h0, 1'b0, "R2 invalid code 3h");
    reject(4'h7, 4'h0, 1'b0, "R2 invalid code 7h");
    reject(4'hB, 4'h0, 1'b1, "R3 demand with burst");
    reject(4'h0, 4'h1, 1'b1, "R3 demand with nonzero inner count");
    xfer(4'h0, 4'h0, 16'h0001, 1'b1, 32'h0000_1600, 32'h0000_2600, 1'b0, "R3 demand single legal");
    chk(!err, "R3 legal demand start clears error", 32'(err), 32'(0));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule